// File: doc/BRIEF.md
# Serial-Loaded Strobed Output Latch Driver

This block turns a slow serial stream into a wide bank of parallel indicator outputs. A host moves bits in one at a time on rising edges of a shift clock. An active-low strobe then copies the shift register into an output latch, which drives the parallel outputs. An active-low clear forces every output high without disturbing the bits already shifted in. A cascade output carries the last shift stage, so several blocks can be chained on one data line with a shared shift clock, strobe and clear.

All four control and data inputs arrive without a relation to the system clock. Each passes through a two-flop synchronizer. A shift happens only when a rising edge of the synchronized shift clock is detected. The strobe is level-sensitive, so while it is held low the outputs follow every shift as it happens. The host must keep each shift-clock level for at least three system clocks, and must set the data bit no later than the shift clock rises.

Top module: `sipo_strobe_driver`

## Requirements
- R1: After a synchronous reset, every parallel output is 1 and every shift-register stage is 0, so the cascade output is 0.
- R2: The shift register moves by one stage only on a detected rising edge of the synchronized shift clock. The new bit enters stage 0. Holding the shift clock high or low, with any data activity, causes no further shift.
- R3: After WIDTH shifts and a strobe, the first bit shifted in appears on the highest-numbered parallel output and the last bit on output 0.
- R4: While the synchronized strobe is low and clear is inactive, the latch copies the shift register on every clock, so each shift shows on the outputs.
- R5: While the synchronized strobe is high and clear is inactive, the parallel outputs hold their value through any number of shifts.
- R6: While the synchronized clear is low, every latch bit is 1. The shift-register contents are left unchanged, so a later strobe shows the bits shifted in before the clear.
- R7: Clear takes priority over strobe. With both low, the outputs are all ones.
- R8: The cascade output always equals the last shift stage, and it changes only with a shift, whatever the strobe does.
- R9: A change on an input first sampled at clock edge k acts on the registers at edge k+2 and is visible on the outputs after edge k+2 for the shift register and cascade, and after edge k+2 for the latch when its source is already settled.
- R10: A second block whose serial input is the cascade output of the first receives each bit WIDTH shifts later, so the two behave as one register of 2*WIDTH stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data bit, asynchronous |
| shift_clk | input | 1 | Shift clock, asynchronous, acts on its rising edge |
| strobe_n | input | 1 | Active-low level strobe, asynchronous |
| clear_n | input | 1 | Active-low clear of the output latch, asynchronous |
| par_out | output | WIDTH | Latched parallel outputs |
| cascade_out | output | 1 | Last shift-register stage, for chaining |

## Verification
Random full frames are shifted through two chained instances with the strobe held high. This separates holding (R5) from following (R4), confirms the bit order (R3) and shows that the second instance receives the first frame one frame late (R10). A strobe placed after a pending frame, sampled cycle by cycle, pins the pipeline latency (R9). A shift clock held high while the data toggles shows that only edges shift. Clear asserted during a transparent strobe, then released under a high strobe and followed by a later strobe, shows that clear wins and that it leaves the shift register alone. A behavioural reference model of both instances is compared on every clock.

// File: rtl/sipo_pkg.sv
// Package: shared indices and idle levels for the serial-to-parallel driver.
// Assumes the synchronizer vector is ordered as listed below.
package sipo_pkg;
    localparam int SYNC_SIGS = 4;
    localparam int IDX_SCLK  = 0;
    localparam int IDX_DATA  = 1;
    localparam int IDX_STB   = 2;
    localparam int IDX_CLR   = 3;
    // Inactive levels: clear high, strobe high, data low, shift clock low.
    localparam logic [SYNC_SIGS-1:0] SYNC_IDLE = 4'b1100;
endpackage

// File: rtl/sipo_sync.sv
// Module: sipo_sync
// Brings a vector of asynchronous inputs into the clock domain through a
// chain of STAGES flops per bit. Assumes STAGES >= 2. During reset each
// chain is loaded with that bit's idle level, so no false edge appears at exit.
module sipo_sync #(
    parameter int              N       = 4,
    parameter int              STAGES  = 2,
    parameter logic [N-1:0]    IDLE    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0][STAGES-1:0] chain;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // Shift each raw input through its own flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[g] <= {STAGES{IDLE[g]}};
            end else begin
                chain[g] <= {chain[g][STAGES-2:0], d[g]};
            end
        end
        assign q[g] = chain[g][STAGES-1];
    end
endmodule

// File: rtl/sipo_shift.sv
// Module: sipo_shift
// The serial shift register. Detects a rising edge on the synchronized shift
// clock and moves the register by one stage, taking the synchronized data
// bit into stage 0. Assumes its inputs already come from the synchronizer.
module sipo_shift #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             data_s,
    output logic [WIDTH-1:0] shreg,
    output logic             cascade
);
    logic sclk_q;
    logic shift_en;

    // Remember the previous shift-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign shift_en = sclk_s & ~sclk_q;

    // Move the register on each detected rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (shift_en) shreg <= {shreg[WIDTH-2:0], data_s};
    end

    assign cascade = shreg[WIDTH-1];

    // R2: without a fresh rising edge the register keeps its contents.
    assert_shift_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_s && !sclk_q) |=> $stable(shreg));

    // R2: on an edge every stage takes its neighbour and stage 0 takes data.
    assert_shift_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_s && !sclk_q) |=> (shreg == {$past(shreg[WIDTH-2:0]), $past(data_s)}));
endmodule

// File: rtl/sipo_latch.sv
// Module: sipo_latch
// Output latch. Clear (active low) forces all ones and wins over strobe;
// a low strobe copies the shift register every clock; a high strobe holds.
// Assumes synchronized control inputs.
module sipo_latch #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n_s,
    input  logic             stb_n_s,
    input  logic [WIDTH-1:0] shreg,
    output logic [WIDTH-1:0] lat
);
    // Update the latch by clear, then strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        lat <= '1;
        else if (!clr_n_s) lat <= '1;
        else if (!stb_n_s) lat <= shreg;
    end

    // R6 and R7: an active clear yields all ones regardless of strobe.
    assert_clear_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_s |=> (lat == '1));

    // R5: with clear idle and strobe high the latch holds.
    assert_strobe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_s && stb_n_s) |=> $stable(lat));

    // R4: with clear idle and strobe low the latch tracks the register.
    assert_strobe_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_s && !stb_n_s) |=> (lat == $past(shreg)));
endmodule

// File: rtl/sipo_strobe_driver.sv
// Module: sipo_strobe_driver
// Top of the serial-loaded strobed output latch driver. Synchronizes the four
// asynchronous inputs, shifts serial data on shift-clock rising edges, and
// drives the parallel outputs from a strobed, clearable latch.
// Assumes every input level is held for at least three system clocks.
module sipo_strobe_driver #(
    parameter int WIDTH       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             strobe_n,
    input  logic             clear_n,
    output logic [WIDTH-1:0] par_out,
    output logic             cascade_out
);
    import sipo_pkg::*;

    logic [SYNC_SIGS-1:0] raw_in;
    logic [SYNC_SIGS-1:0] syn_in;
    logic [WIDTH-1:0]     shreg;

    // Gather the raw inputs into the synchronizer vector.
    always_comb begin
        raw_in           = '0;
        raw_in[IDX_SCLK] = shift_clk;
        raw_in[IDX_DATA] = ser_in;
        raw_in[IDX_STB]  = strobe_n;
        raw_in[IDX_CLR]  = clear_n;
    end

    sipo_sync #(
        .N      (SYNC_SIGS),
        .STAGES (SYNC_STAGES),
        .IDLE   (SYNC_IDLE)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    sipo_shift #(.WIDTH(WIDTH)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (syn_in[IDX_SCLK]),
        .data_s  (syn_in[IDX_DATA]),
        .shreg   (shreg),
        .cascade (cascade_out)
    );

    sipo_latch #(.WIDTH(WIDTH)) latch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n_s (syn_in[IDX_CLR]),
        .stb_n_s (syn_in[IDX_STB]),
        .shreg   (shreg),
        .lat     (par_out)
    );

    // R8: the cascade output only moves when a shift edge was seen.
    assert_cascade_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(syn_in[IDX_SCLK] && !$past(syn_in[IDX_SCLK])) |=> $stable(cascade_out));
endmodule

// File: tb/sipo_strobe_driver_tb_top.sv
// Bench: two chained instances, a behavioural per-clock reference model and
// directed checks per requirement. Inputs change 2 ns after a rising edge.
module sipo_strobe_driver_tb_top;
    localparam int W = 24;

    logic clk = 1'b0;
    logic rst_n, ser_in, shift_clk, strobe_n, clear_n;
    logic [W-1:0] par_a, par_b;
    logic casc_a, casc_b;

    always #5 clk = ~clk;

    sipo_strobe_driver #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
        .strobe_n(strobe_n), .clear_n(clear_n), .par_out(par_a), .cascade_out(casc_a));

    sipo_strobe_driver #(.WIDTH(W)) dut_b (
        .clk(clk), .rst_n(rst_n), .ser_in(casc_a), .shift_clk(shift_clk),
        .strobe_n(strobe_n), .clear_n(clear_n), .par_out(par_b), .cascade_out(casc_b));

    int checks = 0;
    int fails  = 0;
    bit mon_en = 0;
    bit done   = 0;

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: inputs take effect two sampled edges late.
    logic [3:0]   h_sc, h_stb, h_clr;
    logic [3:0]   h_d [2];
    logic [W-1:0] m_sh [2];
    logic [W-1:0] m_lat [2];

    always @(negedge clk) begin
        if (mon_en) begin
            chk(par_a, m_lat[0], "R9 model par A");
            chk(par_b, m_lat[1], "R10 model par B");
            chk({{(W-1){1'b0}}, casc_a}, {{(W-1){1'b0}}, m_sh[0][W-1]}, "R8 model cascade A");
            chk({{(W-1){1'b0}}, casc_b}, {{(W-1){1'b0}}, m_sh[1][W-1]}, "R8 model cascade B");
        end
        h_sc   = {h_sc[2:0], shift_clk};
        h_stb  = {h_stb[2:0], strobe_n};
        h_clr  = {h_clr[2:0], clear_n};
        h_d[0] = {h_d[0][2:0], ser_in};
        h_d[1] = {h_d[1][2:0], casc_a};
        if (!rst_n) begin
            h_sc = '0; h_stb = '1; h_clr = '1;
            for (int i = 0; i < 2; i++) begin
                h_d[i] = '0; m_sh[i] = '0; m_lat[i] = '1;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (!h_clr[2])      m_lat[i] = '1;
                else if (!h_stb[2]) m_lat[i] = m_sh[i];
                if (h_sc[2] && !h_sc[3]) m_sh[i] = {m_sh[i][W-2:0], h_d[i][2]};
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic shift_bit(input logic b);
        ser_in = b; shift_clk = 1'b1; tick(3);
        shift_clk = 1'b0; tick(3);
    endtask

    task automatic shift_frame(input logic [W-1:0] f);
        for (int i = W - 1; i >= 0; i--) shift_bit(f[i]);
    endtask

    task automatic pulse_strobe();
        strobe_n = 1'b0; tick(3);
        strobe_n = 1'b1; tick(4);
    endtask

    // Bench bookkeeping of expected shift-register and latch contents.
    logic [W-1:0] ea, eb, la, lb, f;

    initial begin
        rst_n = 0; ser_in = 0; shift_clk = 0; strobe_n = 1; clear_n = 1;
        tick(2); mon_en = 1; tick(2); rst_n = 1; tick(1);
        @(negedge clk);
        chk(par_a, '1, "R1 reset latch ones");
        chk({{(W-1){1'b0}}, casc_a}, '0, "R1 reset cascade zero");
        tick(1);
        ea = '0; eb = '0; la = '1; lb = '1;

        for (int k = 0; k < 4; k++) begin
            f = W'($urandom);
            shift_frame(f);
            eb = ea; ea = f;
            @(negedge clk);
            chk(par_a, la, "R5 hold A during shifts");
            chk(par_b, lb, "R5 hold B during shifts");
            chk({{(W-1){1'b0}}, casc_a}, {{(W-1){1'b0}}, f[W-1]}, "R8 cascade first bit");
            tick(1);
            pulse_strobe();
            la = ea; lb = eb;
            @(negedge clk);
            chk(par_a, f, "R3 frame order A");
            chk(par_b, eb, "R10 chained frame B");
            tick(1);
        end

        // R9: latency of a strobe onto a pending frame.
        f = W'($urandom) ^ 24'h5A5A5A;
        shift_frame(f);
        eb = ea; ea = f;
        strobe_n = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk(par_a, la, "R9 latch unchanged before edge k+2");
        @(negedge clk);
        chk(par_a, ea, "R9 latch updated after edge k+2");
        tick(1);

        // R4: transparent strobe, outputs track each shift.
        for (int i = 0; i < 3; i++) begin
            shift_bit(i[0]);
            eb = {eb[W-2:0], ea[W-1]}; ea = {ea[W-2:0], i[0]};
            @(negedge clk);
            chk(par_a, ea, "R4 transparent follow A");
            chk(par_b, eb, "R4 transparent follow B");
            tick(1);
        end

        // R2: held shift clock with toggling data shifts once only.
        ser_in = 1'b1; shift_clk = 1'b1; tick(3);
        for (int i = 0; i < 6; i++) begin ser_in = ~ser_in; tick(1); end
        shift_clk = 1'b0;
        for (int i = 0; i < 6; i++) begin ser_in = ~ser_in; tick(1); end
        eb = {eb[W-2:0], ea[W-1]}; ea = {ea[W-2:0], 1'b1};
        @(negedge clk);
        chk(par_a, ea, "R2 single shift per edge");
        tick(1);

        // R7 then R6: clear beats strobe, shift register survives.
        clear_n = 1'b0; tick(4);
        @(negedge clk);
        chk(par_a, '1, "R7 clear wins over strobe");
        tick(1);
        strobe_n = 1'b1; tick(4);
        clear_n = 1'b1; tick(4);
        @(negedge clk);
        chk(par_a, '1, "R6 ones held after clear");
        tick(1);
        strobe_n = 1'b0; tick(4);
        @(negedge clk);
        chk(par_a, ea, "R6 shift register untouched by clear");
        chk(par_b, eb, "R6 chained register untouched by clear");
        tick(1);
        strobe_n = 1'b1; tick(4);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule